// File: doc/BRIEF.md
# Two-Bank Owned GPIO Controller

This block drives and samples a set of general-purpose lines, 32 by default. Two mirrored register banks sit in front of them: a shared bank that any bus master may write, and a guarded bank whose writes are accepted only while the `priv_ok` input is high. A per-line owner register, itself writable only with privilege, chooses the bank that controls each line. The owning bank supplies the line's output value, its direction and its interrupt settings. Reads of the shared bank are never blocked.

Interrupts are level-sensitive only. Each line compares its synchronised input with a polarity bit. While they match, the line's pending flag is set on every clock. Software clears a flag by writing a one to it through the owning bank. Each bank raises its own interrupt output from the pending, enabled lines it owns. Edge detection is left to software, which can flip the polarity bit after each event.

The register port is a simple single-cycle interface. A write is taken on the rising clock edge while `bus_we` is high. Read data follows `bus_word` combinationally.

Top module: `gpio_dual_bank`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after it rises, the owner, direction, trigger-polarity, interrupt-enable and pending registers of both banks read zero. `pad_oe` is zero and both interrupt outputs are low.
- R2: `bus_word` is the byte offset divided by four. Bit 3 selects the bank: 0 is the shared bank (byte offsets 0x00–0x1C) and 1 is the guarded bank (0x20–0x3C). Bits 2:0 select the register in that bank: 0 output value, 1 direction, 2 input, 3 trigger polarity, 4 pending, 5 interrupt enable, 6 input copy. Index 7 is the line-enable register in the shared half (0x1C) and the owner register in the guarded half (0x3C). Both are read/write.
- R3: Owner bit 1 gives the line to the shared bank and owner bit 0 gives it to the guarded bank. `pad_oe` and `pad_out` for a line come from the owning bank's direction and output-value bits, where direction 1 means output. The other bank's bits for that line have no effect on the pad.
- R4: Writes to any guarded-bank register, the owner register or the line-enable register are dropped while `priv_ok` is low. Shared-bank registers accept writes regardless of `priv_ok`.
- R5: The input register and both input-copy registers return `pad_in` through a two-flop synchroniser. A pad change is first visible after the second rising edge.
- R6: On every rising edge where a line's synchronised input equals the owning bank's trigger-polarity bit (1 = active high, 0 = active low), the line's pending flag is set. A flag stays set after the condition goes away. The block has no edge detection.
- R7: Writing 1 to a pending bit through the owning bank clears it on that edge. Writing 0 has no effect. Writing through the non-owning bank has no effect. A clear wins over a set on the same edge, so a flag whose condition still holds sets again one edge later.
- R8: A pending-register read returns only the bits of lines that bank owns, with zeros elsewhere.
- R9: `irq_sec` is high when any line owned by the shared bank has both its pending flag and its shared interrupt-enable bit set. `irq_pri` is high under the same condition for the guarded bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_ok | input | 1 | High when privileged writes are permitted |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_word | input | 4 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word` |
| pad_in | input | LINES | Raw pad input levels |
| pad_out | output | LINES | Pad output values |
| pad_oe | output | LINES | Pad output enables |
| irq_sec | output | 1 | Shared-bank interrupt |
| irq_pri | output | 1 | Guarded-bank interrupt |

## Verification
The bench clears flags while their level condition still holds. It expects zero in the cycle right after the clear and the re-set bit pattern one edge later. A design that let set win over clear, or that only latched edges, would show the wrong value in one of those two cycles. It also writes pending and enable bits through the bank that does not own a line, and attempts guarded, owner and enable writes with privilege removed. A design that decoded ownership wrongly or ignored `priv_ok` would change a read-back value or an interrupt output that must not move. Finally, it moves a line between banks and samples the input registers one and two edges after a pad change, which exposes a missing synchroniser stage and flag bits that leak across banks.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  localparam int unsigned BUS_W = 32;

  // register index within one bank half (bus_word[2:0])
  localparam logic [2:0] IX_DOUT  = 3'd0;
  localparam logic [2:0] IX_DDIR  = 3'd1;
  localparam logic [2:0] IX_DIN   = 3'd2;
  localparam logic [2:0] IX_TPOL  = 3'd3;
  localparam logic [2:0] IX_PEND  = 3'd4;
  localparam logic [2:0] IX_IEN   = 3'd5;
  localparam logic [2:0] IX_INCPY = 3'd6;
  localparam logic [2:0] IX_SPEC  = 3'd7;

  // per-line select: sel=1 picks a (shared), sel=0 picks b (guarded)
  function automatic logic [BUS_W-1:0] steer(input logic [BUS_W-1:0] sel,
                                             input logic [BUS_W-1:0] a,
                                             input logic [BUS_W-1:0] b);
    return (sel & a) | (~sel & b);
  endfunction

  // level condition: input equals polarity bit
  function automatic logic [BUS_W-1:0] level_hit(input logic [BUS_W-1:0] lvl_in,
                                                 input logic [BUS_W-1:0] pol);
    return ~(lvl_in ^ pol);
  endfunction
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_chk
      // R5: each stage carries the previous stage one edge later
      a_r5_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
        stg[k] == $past(stg[k-1]));
    end
  endgenerate
endmodule

// File: rtl/gdb_bank.sv
module gdb_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [2:0]   idx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_dout,
  output logic [W-1:0] q_ddir,
  output logic [W-1:0] q_tpol,
  output logic [W-1:0] q_ien
);
  import gdb_pkg::*;

  logic hit_dout, hit_ddir, hit_tpol, hit_ien;
  assign hit_dout = wr && (idx == IX_DOUT);
  assign hit_ddir = wr && (idx == IX_DDIR);
  assign hit_tpol = wr && (idx == IX_TPOL);
  assign hit_ien  = wr && (idx == IX_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_dout <= '0;
      q_ddir <= '0;
      q_tpol <= '0;
      q_ien  <= '0;
    end else begin
      if (hit_dout) q_dout <= wdata;
      if (hit_ddir) q_ddir <= wdata;
      if (hit_tpol) q_tpol <= wdata;
      if (hit_ien)  q_ien  <= wdata;
    end
  end

  // R4: a bank not selected for writing holds its direction bits
  a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q_ddir));
endmodule

// File: rtl/gdb_flags.sv
module gdb_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag[i] <= 1'b0;
        else if (clr[i]) flag[i] <= 1'b0;
        else if (hit[i]) flag[i] <= 1'b1;
      end

      // R7: a clear strobe empties the flag on that edge
      a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr[i] |=> !flag[i]);
      // R6: level condition without clear sets the flag
      a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && !clr[i]) |=> flag[i]);
      // R6: flag is sticky until cleared
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !clr[i]) |=> flag[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int unsigned LINES      = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_ok,
  input  logic             bus_we,
  input  logic [3:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic             irq_sec,
  output logic             irq_pri
);
  import gdb_pkg::*;

  localparam int unsigned W = LINES;

  // decode
  logic       in_guard;
  logic [2:0] idx;
  logic       wr_sh, wr_gd, wr_en_reg, wr_owner;
  assign in_guard  = bus_word[3];
  assign idx       = bus_word[2:0];
  assign wr_sh     = bus_we && !in_guard && (idx != IX_SPEC);
  assign wr_gd     = bus_we &&  in_guard && (idx != IX_SPEC) && priv_ok;
  assign wr_en_reg = bus_we && !in_guard && (idx == IX_SPEC) && priv_ok;
  assign wr_owner  = bus_we &&  in_guard && (idx == IX_SPEC) && priv_ok;

  logic [W-1:0] wd;
  assign wd = bus_wdata[W-1:0];

  // special registers
  logic [W-1:0] owner, line_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner   <= '0;
      line_en <= '0;
    end else begin
      if (wr_owner)  owner   <= wd;
      if (wr_en_reg) line_en <= wd;
    end
  end

  // banks
  logic [W-1:0] s_dout, s_ddir, s_tpol, s_ien;
  logic [W-1:0] g_dout, g_ddir, g_tpol, g_ien;

  gdb_bank #(.W(W)) u_shared (
    .clk(clk), .rst_n(rst_n), .wr(wr_sh), .idx(idx), .wdata(wd),
    .q_dout(s_dout), .q_ddir(s_ddir), .q_tpol(s_tpol), .q_ien(s_ien));

  gdb_bank #(.W(W)) u_guarded (
    .clk(clk), .rst_n(rst_n), .wr(wr_gd), .idx(idx), .wdata(wd),
    .q_dout(g_dout), .q_ddir(g_ddir), .q_tpol(g_tpol), .q_ien(g_ien));

  // input synchroniser
  logic [W-1:0] sync_in;
  gdb_sync #(.W(W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in));

  // 32-bit views for the package helpers
  logic [BUS_W-1:0] own32, sel_pol32, in32;
  always_comb begin
    own32 = '0;
    own32[W-1:0] = owner;
    in32 = '0;
    in32[W-1:0] = sync_in;
  end

  // pad steering
  logic [BUS_W-1:0] oe32, out32, pol32_s, pol32_g;
  always_comb begin
    pol32_s = '0; pol32_s[W-1:0] = s_tpol;
    pol32_g = '0; pol32_g[W-1:0] = g_tpol;
  end
  always_comb begin
    logic [BUS_W-1:0] a, b;
    a = '0; b = '0;
    a[W-1:0] = s_ddir; b[W-1:0] = g_ddir;
    oe32 = steer(own32, a, b);
    a[W-1:0] = s_dout; b[W-1:0] = g_dout;
    out32 = steer(own32, a, b);
  end
  assign sel_pol32 = steer(own32, pol32_s, pol32_g);
  assign pad_oe  = oe32[W-1:0];
  assign pad_out = out32[W-1:0];

  // pending flags
  logic [BUS_W-1:0] hit32;
  logic [W-1:0]     level_ev, clr_ev, flag;
  assign hit32    = level_hit(in32, sel_pol32);
  assign level_ev = hit32[W-1:0];
  assign clr_ev   = ((wr_sh && idx == IX_PEND) ? (wd &  owner) : '0)
                  | ((wr_gd && idx == IX_PEND) ? (wd & ~owner) : '0);

  gdb_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(level_ev), .clr(clr_ev), .flag(flag));

  // interrupts
  logic [W-1:0] fire_s, fire_g;
  assign fire_s  = flag &  owner & s_ien;
  assign fire_g  = flag & ~owner & g_ien;
  assign irq_sec = |fire_s;
  assign irq_pri = |fire_g;

  // read mux
  always_comb begin
    logic [W-1:0] v;
    v = '0;
    unique case (idx)
      IX_DOUT:  v = in_guard ? g_dout : s_dout;
      IX_DDIR:  v = in_guard ? g_ddir : s_ddir;
      IX_DIN:   v = sync_in;
      IX_TPOL:  v = in_guard ? g_tpol : s_tpol;
      IX_PEND:  v = in_guard ? (flag & ~owner) : (flag & owner);
      IX_IEN:   v = in_guard ? g_ien : s_ien;
      IX_INCPY: v = sync_in;
      IX_SPEC:  v = in_guard ? owner : line_en;
      default:  v = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[W-1:0] = v;
  end

  // R4: owner and enable registers locked without privilege
  a_r4_owner_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !priv_ok) |=> ($stable(owner) && $stable(line_en)));
  // R4: guarded bank output value locked without privilege
  a_r4_guard_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !priv_ok && in_guard) |=> $stable(g_dout));
  // R9: no pending flag means no interrupt
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == '0) |-> (!irq_sec && !irq_pri));
  // R8: pending read never shows lines of the other bank
  a_r8_pend_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IX_PEND) |-> ((bus_rdata[W-1:0] & (in_guard ? owner : ~owner)) == '0));
  // R7: a clear of a line through the non-owning bank never empties it
  a_r7_foreign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh && idx == IX_PEND && ((flag & ~owner & wd) != '0) && !wr_gd)
      |=> ((flag & ~$past(owner) & $past(flag & ~owner & wd)) == $past(flag & ~owner & wd)));
endmodule

// File: tb/test_gpio_dual_bank.sv
module test_gpio_dual_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_ok = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_sec, irq_pri;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dual_bank i_gpio_dual_bank (
    .clk(clk), .rst_n(rst_n), .priv_ok(priv_ok), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_sec(irq_sec), .irq_pri(irq_pri));

  // scoreboard
  typedef struct {
    int          sel;   // 0 read data, 1 pad_oe, 2 pad_out, 3 {irq_sec,irq_pri}
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return bus_rdata;
      1: return pad_oe;
      2: return pad_out;
      default: return {30'd0, irq_sec, irq_pri};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      act = observe(it.sel);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d word=%0d: actual %h expected %h",
                 it.req, it.sel, bus_word, act, it.exp);
      end
    end
  end

  task automatic push(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
    #0;
  endtask

  task automatic chk_rd(logic [3:0] w, logic [31:0] exp, string req);
    bus_word = w;
    push(0, exp, req);
  endtask

  task automatic chk_port(int sel, logic [31:0] exp, string req);
    push(sel, exp, req);
  endtask

  task automatic wr(logic [3:0] w, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin : driver
    tick(3);
    rst_n = 1'b1;
    // R1: right after release, before any edge
    chk_rd(4'd4,  32'h0, "R1 shared pending");
    chk_rd(4'd12, 32'h0, "R1 guarded pending");
    chk_rd(4'd15, 32'h0, "R1 owner");
    chk_rd(4'd1,  32'h0, "R1 shared dir");
    chk_rd(4'd9,  32'h0, "R1 guarded dir");
    chk_rd(4'd13, 32'h0, "R1 guarded ien");
    chk_rd(4'd3,  32'h0, "R1 shared polarity");
    chk_port(1, 32'h0, "R1 pad_oe");
    chk_port(3, 32'h0, "R1 irq");

    // R4: no privilege
    wr(4'd15, 32'hFFFF0000);
    wr(4'd9,  32'hFFFFFFFF);
    wr(4'd7,  32'hA5A5A5A5);
    wr(4'd1,  32'h0000FF00);
    chk_rd(4'd15, 32'h0, "R4 owner locked");
    chk_rd(4'd9,  32'h0, "R4 guarded dir locked");
    chk_rd(4'd7,  32'h0, "R4 enable locked");
    chk_rd(4'd1,  32'h0000FF00, "R4 shared always writable");
    chk_port(1, 32'h0, "R3 non-owner dir ignored");

    // privilege on
    priv_ok = 1'b1;
    wr(4'd7,  32'hA5A5A5A5);
    chk_rd(4'd7, 32'hA5A5A5A5, "R2 enable at index 7 shared half");
    wr(4'd9,  32'h000000FF);
    wr(4'd8,  32'h0000000F);
    wr(4'd0,  32'h00003000);
    chk_port(1, 32'h000000FF, "R3 guarded dir drives oe");
    chk_port(2, 32'h0000000F, "R3 guarded out drives pad");
    wr(4'd15, 32'h0000FF00);
    chk_rd(4'd15, 32'h0000FF00, "R2 owner at index 15");
    chk_port(1, 32'h0000FFFF, "R3 mixed ownership oe");
    chk_port(2, 32'h0000300F, "R3 mixed ownership out");

    // R5: synchroniser latency
    pad_in = 32'h12345678;
    tick(1);
    chk_rd(4'd2, 32'h0, "R5 one edge not yet visible");
    tick(1);
    chk_rd(4'd2,  32'h12345678, "R5 shared input");
    chk_rd(4'd6,  32'h12345678, "R5 shared input copy");
    chk_rd(4'd10, 32'h12345678, "R5 guarded input");
    chk_rd(4'd14, 32'h12345678, "R5 guarded input copy");

    // R8: pending filtered by owner (all flags set while inputs were low)
    chk_rd(4'd12, 32'hFFFF00FF, "R8 guarded pending view");
    chk_rd(4'd4,  32'h0000FF00, "R8 shared pending view");
    chk_port(3, 32'h0, "R9 masked flags no irq");

    // R7: clear, then re-set while active-low condition holds
    wr(4'd12, 32'hFFFFFFFF);
    chk_rd(4'd12, 32'h0, "R7 clear on write edge");
    chk_rd(4'd4,  32'h0000FF00, "R7 guarded write leaves shared lines");
    tick(1);
    chk_rd(4'd12, 32'hEDCB0087, "R7 re-set next edge");
    wr(4'd4, 32'h0);
    chk_rd(4'd4, 32'h0000FF00, "R7 writing zero no effect");
    wr(4'd4, 32'hFFFFFFFF);
    tick(1);
    chk_rd(4'd4,  32'h0000A900, "R7 shared clear and re-set");
    chk_rd(4'd12, 32'hEDCB0087, "R7 shared write leaves guarded lines");

    // R6: active-high polarity
    wr(4'd11, 32'hFFFFFFFF);
    wr(4'd12, 32'hFFFFFFFF);
    chk_rd(4'd12, 32'h0, "R6 cleared");
    tick(1);
    chk_rd(4'd12, 32'h12340078, "R6 active-high match");

    // R9: interrupts per bank
    wr(4'd13, 32'h00000008);
    chk_port(3, 32'h1, "R9 guarded irq");
    wr(4'd13, 32'h00000100);
    chk_port(3, 32'h0, "R9 guarded enable on shared line ignored");
    wr(4'd5, 32'h0000A900);
    chk_port(3, 32'h2, "R9 shared irq");
    wr(4'd5, 32'h00000001);
    chk_port(3, 32'h0, "R9 shared enable on guarded line ignored");

    // R6: no edge detection; vanished level stays clear after clear
    pad_in = 32'h12345670;
    tick(3);
    wr(4'd12, 32'hFFFFFFFF);
    tick(1);
    chk_rd(4'd12, 32'h12340070, "R6 level gone stays clear");

    // R8/R3: move all lines to guarded bank
    wr(4'd15, 32'h0);
    tick(1);
    chk_rd(4'd12, 32'h1234FF70, "R8 moved lines show in guarded");
    chk_rd(4'd4,  32'h0, "R8 shared owns nothing");
    chk_port(1, 32'h000000FF, "R3 oe after move");
    chk_port(2, 32'h0000000F, "R3 out after move");

    // R4: privilege removed again
    priv_ok = 1'b0;
    wr(4'd12, 32'hFFFFFFFF);
    chk_rd(4'd12, 32'h1234FF70, "R4 guarded clear dropped");
    wr(4'd15, 32'hFFFFFFFF);
    chk_rd(4'd15, 32'h0, "R4 owner write dropped");

    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule